// File: doc/BRIEF.md
# PS/2 Serial Link Engine

This block moves bytes in both directions over one open-collector clock/data pair, with the attached device supplying every clock edge. Both lines come in as plain inputs, and the block pulls a line low through an enable output. An external open-drain pad or the board forms the wired-AND. The device line inputs pass through a two-flop synchroniser. Falling edges of the device clock are found in the system clock domain.

On receive, the engine collects an 11-bit frame: a start bit, eight data bits with the least significant first, an odd-parity bit and a stop bit. It offers the byte on a valid/ready pair together with a parity-error flag. While a byte waits for the consumer, the engine holds the clock line low so that the device cannot start another frame. On transmit, it accepts one byte and then runs the request sequence: clock low, data low, clock released. It shifts the bits out after each falling device clock and waits for the device to pull data low on the eleventh clock. Only one byte can be outstanding at a time. Time-outs in either direction drop the frame and raise a flag for the host status logic.

Receive states: `RX_IDLE` goes to `RX_SHIFT` on a start bit (falling clock with data low). `RX_SHIFT` goes to `RX_HOLD` when the stop bit is high, and back to `RX_IDLE` when the stop bit is low or on time-out. `RX_HOLD` returns to `RX_IDLE` on accept. Transmit states: `TX_IDLE` goes to `TX_INHIBIT` on accept. `TX_INHIBIT` goes to `TX_REQ` after the hold time. `TX_REQ` goes to `TX_SHIFT` on the first falling clock. `TX_SHIFT` goes to `TX_ACK` after the parity bit. `TX_ACK` goes to `TX_IDLE` on acknowledge. Every state after `TX_IDLE` returns to `TX_IDLE` on time-out.

Top module: `ps2_link`

## Requirements
- R1: A received frame (start 0, data bit 0 first through bit 7, parity, stop 1) is presented as `rx_data` with `rx_valid` high.
- R2: The received data and parity bits together must hold an odd number of ones. Otherwise `rx_par_err` is 1 alongside the byte, and the byte is still delivered.
- R3: A frame whose stop bit is 0 is discarded and no byte is presented.
- R4: While `rx_valid` is high and `rx_ready` is low, `rx_data` and `rx_par_err` stay stable and `ps2_clk_oe` is 1.
- R5: If no falling device clock arrives for `RX_TMO_CYC` cycles in the middle of a frame, the partial frame is dropped and `rx_tmo` goes to 1. It stays 1 until the next received byte is accepted.
- R6: A transmit first drives the clock low for at least `INHIBIT_CYC` cycles. It then pulls data low with the clock released. After each falling device clock it presents data bit 0 through 7 and then odd parity. After the tenth falling clock it releases data, which the device reads as the stop bit.
- R7: After a byte is accepted, `tx_ready` stays 0 until the device pulls data low at a falling clock after the stop bit. That acknowledge gives a one-cycle `tx_done`.
- R8: If no acknowledge comes within `TX_TMO_CYC` cycles of acceptance, both lines are released, `tx_ready` returns, and `tx_tmo` goes to 1 until the next byte is accepted.
- R9: While `hold_req` is 1 and no transmit is running, `ps2_clk_oe` is 1. It drops once the request is removed and no received byte is pending.
- R10: After reset both line enables are 0, `rx_valid`, `tx_done`, `rx_tmo` and `tx_tmo` are 0, and `tx_ready` is 1.
- R11: `tx_ready` is 0 while a received byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | 1 | Device clock line level |
| ps2_dat_i | input | 1 | Device data line level |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the data line low |
| hold_req | input | 1 | Request to inhibit the device by holding clock low |
| tx_valid | input | 1 | Byte to send is offered |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Engine can accept a byte |
| tx_done | output | 1 | One-cycle pulse on device acknowledge |
| tx_tmo | output | 1 | Transmit time-out flag |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Received byte |
| rx_par_err | output | 1 | Parity error of the presented byte |
| rx_tmo | output | 1 | Receive time-out flag |

## Verification
Some rules are checked by assertions on every cycle. Accepting a byte blocks a second one. A presented byte and its flag hold still while unaccepted, and the clock stays pulled low meanwhile. The bit index never passes the stop position. Time-out flags rise only as the machine lands in idle. The transmit request follows the inhibit phase. The bench's scenarios are needed for the rest: the bit order on the wire, the parity value, discarding on a bad stop bit, the length of the inhibit phase, and the exact moment each time-out fires and clears. A cycle-level reference in the bench also tracks the outstanding-byte state and the pending-byte inhibit on every clock.

// File: rtl/ps2_link_pkg.sv
package ps2_link_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_HOLD
    } rx_state_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_INHIBIT,
        TX_REQ,
        TX_SHIFT,
        TX_ACK
    } tx_state_e;

    localparam int FRAME_DATA_BITS = 8;
    localparam int RX_LAST_IDX     = FRAME_DATA_BITS + 1;

endpackage

// File: rtl/ps2_sync.sv
module ps2_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    input  logic line_dat,
    output logic dat_s,
    output logic clk_fall
);
    localparam int CW = STAGES + 1;

    logic [CW-1:0]     csh;
    logic [STAGES-1:0] dsh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csh <= '1;
            dsh <= '1;
        end else begin
            csh <= {csh[CW-2:0], line_clk};
            dsh <= {dsh[STAGES-2:0], line_dat};
        end
    end

    assign dat_s    = dsh[STAGES-1];
    assign clk_fall = csh[CW-1] & ~csh[CW-2];

endmodule

// File: rtl/ps2_rx_fsm.sv
module ps2_rx_fsm
    import ps2_link_pkg::*;
#(
    parameter int TMO_CYC = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       block,
    input  logic       fall,
    input  logic       dat_s,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_perr,
    output logic       tmo_flag,
    output logic       idle_o
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] TLAST = TW'(TMO_CYC - 1);
    localparam logic [3:0] PAR_IDX  = 4'(FRAME_DATA_BITS);
    localparam logic [3:0] STOP_IDX = 4'(RX_LAST_IDX);

    rx_state_e     state, nxt;
    logic [3:0]    idx;
    logic [7:0]    sh;
    logic          par;
    logic [TW-1:0] tcnt;
    logic          edge_ok;
    logic          tmo_hit;

    assign edge_ok = fall & en;
    assign tmo_hit = (state == RX_SHIFT) && (tcnt == TLAST) && !edge_ok;

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (edge_ok && !dat_s && !block) nxt = RX_SHIFT;
            RX_SHIFT: begin
                if (tmo_hit) nxt = RX_IDLE;
                else if (edge_ok && idx == STOP_IDX) nxt = dat_s ? RX_HOLD : RX_IDLE;
            end
            RX_HOLD:  if (out_ready) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            sh       <= '0;
            par      <= 1'b0;
            tcnt     <= '0;
            out_data <= '0;
            out_perr <= 1'b0;
            tmo_flag <= 1'b0;
        end else begin
            if (state == RX_SHIFT && !edge_ok) tcnt <= tcnt + 1'b1;
            else                               tcnt <= '0;

            if (state == RX_IDLE) begin
                idx <= '0;
            end else if (state == RX_SHIFT && edge_ok) begin
                if (idx < PAR_IDX)  sh  <= {dat_s, sh[7:1]};
                if (idx == PAR_IDX) par <= dat_s;
                if (idx == STOP_IDX && dat_s) begin
                    out_data <= sh;
                    out_perr <= ~(^{sh, par});
                end
                idx <= idx + 1'b1;
            end

            if (tmo_hit)                          tmo_flag <= 1'b1;
            else if (state == RX_HOLD && out_ready) tmo_flag <= 1'b0;
        end
    end

    always_comb begin
        out_valid = (state == RX_HOLD);
        idle_o    = (state == RX_IDLE);
    end

    // R1
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_SHIFT) |-> (idx <= STOP_IDX));

    // R5
    rx_tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> (state == RX_IDLE));

endmodule

// File: rtl/ps2_tx_fsm.sv
module ps2_tx_fsm
    import ps2_link_pkg::*;
#(
    parameter int INHIBIT_CYC = 25000,
    parameter int TMO_CYC     = 3750000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    input  logic       fall,
    input  logic       dat_s,
    output logic       idle_o,
    output logic       clk_oe,
    output logic       dat_oe,
    output logic       done,
    output logic       tmo_flag
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam int IW = $clog2(INHIBIT_CYC + 1);
    localparam logic [TW-1:0] TLAST = TW'(TMO_CYC - 1);
    localparam logic [IW-1:0] ILAST = IW'(INHIBIT_CYC - 1);
    localparam logic [3:0] PAR_IDX  = 4'(FRAME_DATA_BITS);

    tx_state_e     state, nxt;
    logic [8:0]    sh;
    logic [3:0]    idx;
    logic [TW-1:0] tcnt;
    logic [IW-1:0] icnt;
    logic          ack_seen;
    logic          tmo_hit;

    assign ack_seen = (state == TX_ACK) && fall && !dat_s;
    assign tmo_hit  = (state != TX_IDLE) && (tcnt == TLAST) && !ack_seen;

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:    if (start) nxt = TX_INHIBIT;
            TX_INHIBIT: begin
                if (tmo_hit)            nxt = TX_IDLE;
                else if (icnt == ILAST) nxt = TX_REQ;
            end
            TX_REQ: begin
                if (tmo_hit)   nxt = TX_IDLE;
                else if (fall) nxt = TX_SHIFT;
            end
            TX_SHIFT: begin
                if (tmo_hit)                      nxt = TX_IDLE;
                else if (fall && idx == PAR_IDX)  nxt = TX_ACK;
            end
            TX_ACK: begin
                if (ack_seen || tmo_hit) nxt = TX_IDLE;
            end
            default: nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            idx      <= '0;
            tcnt     <= '0;
            icnt     <= '0;
            tmo_flag <= 1'b0;
        end else begin
            if (state == TX_IDLE) begin
                tcnt <= '0;
                icnt <= '0;
                idx  <= '0;
                if (start) begin
                    sh       <= {~^data, data};
                    tmo_flag <= 1'b0;
                end
            end else begin
                tcnt <= tcnt + 1'b1;
                if (state == TX_INHIBIT) icnt <= icnt + 1'b1;
                if (state == TX_SHIFT && fall && idx < PAR_IDX) idx <= idx + 1'b1;
                if (tmo_hit) tmo_flag <= 1'b1;
            end
        end
    end

    always_comb begin
        clk_oe = 1'b0;
        dat_oe = 1'b0;
        unique case (state)
            TX_IDLE:    ;
            TX_INHIBIT: clk_oe = 1'b1;
            TX_REQ:     dat_oe = 1'b1;
            TX_SHIFT:   dat_oe = ~sh[idx];
            TX_ACK:     ;
            default:    ;
        endcase
        idle_o = (state == TX_IDLE);
        done   = ack_seen;
    end

    // R8
    tx_tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> (state == TX_IDLE));

    // R6
    req_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == TX_REQ) |-> ($past(state) == TX_INHIBIT));

endmodule

// File: rtl/ps2_link.sv
module ps2_link
    import ps2_link_pkg::*;
#(
    parameter int INHIBIT_CYC = 25000,
    parameter int RX_TMO_CYC  = 500000,
    parameter int TX_TMO_CYC  = 3750000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       ps2_clk_oe,
    output logic       ps2_dat_oe,
    input  logic       hold_req,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       tx_done,
    output logic       tx_tmo,
    output logic       rx_valid,
    input  logic       rx_ready,
    output logic [7:0] rx_data,
    output logic       rx_par_err,
    output logic       rx_tmo
);
    localparam int GUARD = SYNC_STAGES + 2;

    logic             dat_s, clk_fall;
    logic             tx_idle, rx_idle, tx_clk_oe, tx_fire, rx_en;
    logic [GUARD-1:0] oe_hist;

    ps2_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_clk (ps2_clk_i),
        .line_dat (ps2_dat_i),
        .dat_s    (dat_s),
        .clk_fall (clk_fall)
    );

    assign tx_ready   = tx_idle & rx_idle;
    assign tx_fire    = tx_valid & tx_ready;
    assign ps2_clk_oe = tx_clk_oe | (tx_idle & (hold_req | rx_valid));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_hist <= '0;
        else        oe_hist <= {oe_hist[GUARD-2:0], ps2_clk_oe};
    end

    assign rx_en = tx_idle & ~ps2_clk_oe & ~(|oe_hist);

    ps2_rx_fsm #(.TMO_CYC(RX_TMO_CYC)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .block     (tx_fire),
        .fall      (clk_fall),
        .dat_s     (dat_s),
        .out_ready (rx_ready),
        .out_valid (rx_valid),
        .out_data  (rx_data),
        .out_perr  (rx_par_err),
        .tmo_flag  (rx_tmo),
        .idle_o    (rx_idle)
    );

    ps2_tx_fsm #(.INHIBIT_CYC(INHIBIT_CYC), .TMO_CYC(TX_TMO_CYC)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tx_fire),
        .data     (tx_data),
        .fall     (clk_fall),
        .dat_s    (dat_s),
        .idle_o   (tx_idle),
        .clk_oe   (tx_clk_oe),
        .dat_oe   (ps2_dat_oe),
        .done     (tx_done),
        .tmo_flag (tx_tmo)
    );

    // R7
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R4
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_par_err)));

    // R4
    rx_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ps2_clk_oe);

endmodule

// File: tb/ps2_link_tb.sv
`timescale 1ns/1ps
module ps2_link_tb;
    localparam int INH  = 40;
    localparam int RTMO = 600;
    localparam int TTMO = 2000;
    localparam int H    = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_clk = 1'b1, dev_dat = 1'b1;
    logic hold_req = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0;
    logic [7:0] tx_data = '0;
    logic ps2_clk_oe, ps2_dat_oe, tx_ready, tx_done, tx_tmo;
    logic rx_valid, rx_par_err, rx_tmo;
    logic [7:0] rx_data;
    logic kclk, kdat;

    int checks = 0, failures = 0;
    int acc_cnt = 0, done_cnt = 0, run = 0, max_run = 0;
    bit outstanding = 0, prev_ready = 0, prev_tmo = 0, finished = 0;

    always #2 clk = ~clk;

    assign kclk = dev_clk & ~ps2_clk_oe;
    assign kdat = dev_dat & ~ps2_dat_oe;

    ps2_link #(.INHIBIT_CYC(INH), .RX_TMO_CYC(RTMO), .TX_TMO_CYC(TTMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .ps2_clk_i(kclk), .ps2_dat_i(kdat),
        .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe), .hold_req(hold_req),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_done(tx_done), .tx_tmo(tx_tmo), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_tmo(rx_tmo));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Reference model evaluated on every clock (negedge, between bench drives)
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_tmo && !prev_tmo) outstanding = 0;
            if (tx_valid && prev_ready) begin
                outstanding = 1;
                acc_cnt++;
            end
            checks++;
            if (outstanding && tx_ready) begin
                failures++;
                $display("FAIL R7 model: tx_ready actual=1 expected=0 at %0t", $time);
            end
            checks++;
            if (rx_valid && !ps2_clk_oe) begin
                failures++;
                $display("FAIL R4 model: clk_oe actual=0 expected=1 at %0t", $time);
            end
            if (tx_done) begin
                outstanding = 0;
                done_cnt++;
            end
            if (ps2_clk_oe) run++; else run = 0;
            if (run > max_run) max_run = run;
        end
        prev_ready = tx_ready;
        prev_tmo   = tx_tmo;
    end

    task automatic dev_send(input logic [7:0] b, input bit flip_par, input bit bad_stop, input int nbits);
        logic [10:0] bits;
        bits = {~bad_stop, (~^b) ^ flip_par, b, 1'b0};
        for (int i = 0; i < nbits; i++) begin
            dev_dat = bits[i];
            step(H/2);
            dev_clk = 1'b0;
            step(H);
            dev_clk = 1'b1;
            step(H/2);
        end
        dev_dat = 1'b1;
    endtask

    task automatic dev_recv(output logic [9:0] got, input bit do_ack);
        while (!(kclk && !kdat)) step(1);
        for (int k = 0; k < 10; k++) begin
            step(H);
            dev_clk = 1'b0;
            step(H);
            dev_clk = 1'b1;
            got[k] = kdat;
        end
        if (do_ack) dev_dat = 1'b0;
        step(H);
        dev_clk = 1'b0;
        step(H);
        dev_clk = 1'b1;
        dev_dat = 1'b1;
    endtask

    task automatic take_rx;
        rx_ready = 1'b1;
        step(1);
        rx_ready = 1'b0;
    endtask

    initial begin
        logic [9:0] got;
        int a0, d0;
        step(3);
        rst_n = 1'b1;
        step(2);
        // R10 reset state
        check("R10 clk_oe", ps2_clk_oe, 0);
        check("R10 dat_oe", ps2_dat_oe, 0);
        check("R10 rx_valid", rx_valid, 0);
        check("R10 tx_ready", tx_ready, 1);
        check("R10 flags", {tx_done, tx_tmo, rx_tmo}, 0);

        // R1 good frame, R4 hold, R11 tx blocked
        dev_send(8'hA5, 0, 0, 11);
        step(2);
        check("R1 valid", rx_valid, 1);
        check("R1 data", rx_data, 8'hA5);
        check("R2 no perr", rx_par_err, 0);
        check("R4 clock held", ps2_clk_oe, 1);
        check("R11 tx_ready", tx_ready, 0);
        step(30);
        check("R4 stable data", {rx_valid, rx_data}, {1'b1, 8'hA5});
        take_rx();
        check("R4 released", rx_valid, 0);
        step(6);

        // R2 parity error still delivers
        dev_send(8'h3C, 1, 0, 11);
        step(2);
        check("R2 valid", rx_valid, 1);
        check("R2 data", rx_data, 8'h3C);
        check("R2 perr", rx_par_err, 1);
        take_rx();
        step(6);
        dev_send(8'h01, 0, 0, 11);
        step(2);
        check("R2 perr clear", {rx_data, rx_par_err}, {8'h01, 1'b0});
        take_rx();
        step(6);

        // R3 bad stop
        dev_send(8'h77, 0, 1, 11);
        step(50);
        check("R3 discarded", rx_valid, 0);
        check("R3 tx_ready back", tx_ready, 1);

        // R6 R7 transmit with ack, tx_valid held through the transfer
        a0 = acc_cnt; d0 = done_cnt; max_run = 0;
        tx_data = 8'h5A;
        tx_valid = 1'b1;
        fork
            dev_recv(got, 1);
            begin
                while (!tx_done) step(1);
                tx_valid = 1'b0;
            end
        join
        step(10);
        check("R6 data bits", got[7:0], 8'h5A);
        check("R6 parity bit", got[8], ~^8'h5A);
        check("R6 stop released", got[9], 1);
        check("R6 inhibit length", (max_run >= INH), 1);
        check("R7 single accept", acc_cnt - a0, 1);
        check("R7 done pulse", done_cnt - d0, 1);
        check("R7 ready back", tx_ready, 1);
        check("R8 no tmo", tx_tmo, 0);
        check("R6 lines free", {ps2_clk_oe, ps2_dat_oe}, 0);

        // R8 no acknowledge
        tx_data = 8'h00;
        tx_valid = 1'b1;
        step(1);
        tx_valid = 1'b0;
        dev_recv(got, 0);
        step(200);
        check("R7 waiting for ack", {tx_ready, tx_tmo}, 2'b00);
        step(TTMO);
        check("R8 tmo flag", tx_tmo, 1);
        check("R8 ready", tx_ready, 1);
        check("R8 lines free", {ps2_clk_oe, ps2_dat_oe}, 0);
        check("R8 no done", done_cnt - d0, 1);
        tx_data = 8'hC3;
        tx_valid = 1'b1;
        step(1);
        tx_valid = 1'b0;
        step(1);
        check("R8 tmo cleared", tx_tmo, 0);
        dev_recv(got, 1);
        step(10);
        check("R6 second byte", got[8:0], {~^8'hC3, 8'hC3});
        step(10);

        // R5 receive stall
        dev_send(8'hF0, 0, 0, 5);
        step(RTMO/2);
        check("R5 not yet", rx_tmo, 0);
        step(RTMO);
        check("R5 tmo flag", rx_tmo, 1);
        check("R5 no byte", rx_valid, 0);
        dev_send(8'h81, 0, 0, 11);
        step(2);
        check("R5 fresh byte", {rx_valid, rx_data}, {1'b1, 8'h81});
        check("R5 flag held", rx_tmo, 1);
        take_rx();
        check("R5 flag cleared", rx_tmo, 0);
        step(6);

        // R9 inhibit request
        hold_req = 1'b1;
        step(5);
        check("R9 clock held", ps2_clk_oe, 1);
        hold_req = 1'b0;
        step(2);
        check("R9 clock freed", ps2_clk_oe, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule